// File: doc/BRIEF.md
# DDR Performance Counter Unit

This block watches a memory controller and counts what it does. It has four counters of width `CNT_W`. Counter 0 is the master cycle counter and counts clock cycles only. Counters 1 to 3 each pick one event from a vector of single-cycle strobes that the controller supplies, using an 8-bit event code. Software reaches the unit through a plain register port: byte address, write data, write enable and combinational read data. An interrupt output signals that the master counter has run out.

The master counter controls the whole unit. While it is disabled, or after it wraps, every counter holds its value. When it wraps it also raises a level interrupt. To make that wrap come sooner, a preload byte in each control register seeds count bits [23:16] at the moment a counter is started. An event counter that wraps raises its own overflow flag but no interrupt. In the default variant it then stops until software clears it.

Top module: `pcu_top`

## Requirements
- R1: After synchronous reset every control register and count reads 0 and `irq_o` is low.
- R2: Counter 0 adds one per clock while its enable is set and its overflow flag is clear. It counts no strobe, and its event code field has no effect on counting.
- R3: Counter n (1..3) adds one for each cycle in which `ev_i[code]` is high, where code is control bits [31:24]. It counts only while its own enable and counter 0's enable are both set and counter 0's overflow flag is clear. Any code of `EV_W` or above counts nothing.
- R4: A write that sets enable (bit 2) while enable is clear loads the count with the byte from bits [23:16] placed at count bits [23:16], with all other count bits 0. This start takes precedence over a clear in the same write.
- R5: For counters 1..3, a write with bit 1 = 0 zeroes the count and the overflow flag. Bit 1 reads back as 1 after any write.
- R6: For counter 0, a write with bit 1 = 1 clears the count and the overflow flag only when the bit 1 last written was 0. A write with bit 1 = 0 alone clears nothing.
- R7: When counter 0 steps from all ones to 0, its overflow flag (bit 0) is set, `irq_o` rises, and every counter then holds its value.
- R8: `irq_o` stays high until the counter 0 clear sequence of R6 completes.
- R9: When an event counter steps from all ones to 0, its flag sets and `irq_o` stays low. With `STOP_ON_OVF=1` the counter then holds at 0 until it is cleared.
- R10: Writes to the count addresses (0x20 + 4n) and to overflow bit 0 have no effect.
- R11: Control register n sits at byte 4n and reads back as {code[31:24], preload[23:16], 13'b0, enable, clear, overflow}. Count n reads at 0x20 + 4n, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe; the write takes effect at the rising edge |
| rdata_o | output | 32 | Read data for `addr_i`; combinational |
| ev_i | input | EV_W | Event strobes, one bit per event code |
| irq_o | output | 1 | Level interrupt: counter 0 has overflowed |

## Verification
The wrap of the master counter and the wrap of an event counter can fall in the same clock edge. The bench provokes this by starting counter 0 and counter 1 from the same preload of 0xFF. Counter 1's strobe is held high, so both counters reach all ones together. A third counter keeps counting a strobe that is always high, which shows the freeze. The bench then checks that both overflow flags are set, that both counts are 0, and that the third counter holds exactly preload plus 65536 across later idle cycles. A separate run lets an event counter wrap alone and checks that no interrupt appears.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int DATA_W  = 32;
    localparam int CODE_W  = 8;
    localparam int PRE_W   = 8;
    localparam int PRE_LSB = 16;
    localparam int CTRL_OFS = 'h00;
    localparam int CNT_OFS  = 'h20;
    localparam int REG_STEP = 4;

    localparam logic [CODE_W-1:0] EVC_RD_CMD  = 8'h20;
    localparam logic [CODE_W-1:0] EVC_WR_CMD  = 8'h21;
    localparam logic [CODE_W-1:0] EVC_PRECHG  = 8'h31;
    localparam logic [CODE_W-1:0] EVC_ACT     = 8'h32;
    localparam logic [CODE_W-1:0] EVC_REFRESH = 8'h37;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PRE_W-1:0]  preload;
        logic [12:0]       rsvd;
        logic              en;
        logic              clr;
        logic              ovf;
    } ctrl_t;

    function automatic int ctrl_addr(input int idx);
        return CTRL_OFS + REG_STEP * idx;
    endfunction

    function automatic int cnt_addr(input int idx);
        return CNT_OFS + REG_STEP * idx;
    endfunction

endpackage

// File: rtl/pcu_evsel.sv
module pcu_evsel
    import pcu_pkg::*;
#(
    parameter int EV_W = 64
) (
    input  logic [EV_W-1:0]   strobe_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              hit_o
);
    localparam int IDX_W = (EV_W > 1) ? $clog2(EV_W) : 1;

    logic in_range;
    assign in_range = ({{(32-CODE_W){1'b0}}, code_i} < 32'(EV_W));

    always_comb begin
        hit_o = 1'b0;
        if (in_range)
            hit_o = strobe_i[code_i[IDX_W-1:0]];
    end
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter
    import pcu_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter bit IS_CYCLE    = 1'b0,
    parameter bit STOP_ON_OVF = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [31:0]      wdata_i,
    input  logic             run_i,
    input  logic             hit_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] cnt_o
);
    ctrl_t wf;
    assign wf = ctrl_t'(wdata_i);

    logic             en_q, clr_q, ovf_q;
    logic [PRE_W-1:0]  pre_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt_q;

    logic start, clear_req, inc, wrap;
    logic [CNT_W-1:0] pre_val;

    logic unused_wbits;
    assign unused_wbits = ^{wf.rsvd, wf.ovf};

    assign start = wr_i & wf.en & ~en_q;

    always_comb begin
        pre_val = '0;
        pre_val[PRE_LSB +: PRE_W] = wf.preload;
    end

    generate
        if (IS_CYCLE) begin : g_cyc
            logic unused_hit;
            assign unused_hit = hit_i;
            assign clear_req  = wr_i & wf.clr & ~clr_q;
            assign inc        = run_i;
        end else begin : g_evt
            assign clear_req = wr_i & ~wf.clr;
            if (STOP_ON_OVF) begin : g_stop
                assign inc = run_i & en_q & hit_i & ~ovf_q;
            end else begin : g_wrapon
                assign inc = run_i & en_q & hit_i;
            end
        end
    endgenerate

    assign wrap = inc & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            clr_q  <= 1'b0;
            ovf_q  <= 1'b0;
            pre_q  <= '0;
            code_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_i) begin
                en_q   <= wf.en;
                pre_q  <= wf.preload;
                code_q <= wf.code;
                clr_q  <= IS_CYCLE ? wf.clr : 1'b1;
            end
            if (start)
                cnt_q <= pre_val;
            else if (clear_req)
                cnt_q <= '0;
            else if (inc)
                cnt_q <= cnt_q + 1'b1;
            if (clear_req)
                ovf_q <= 1'b0;
            else if (wrap)
                ovf_q <= 1'b1;
        end
    end

    assign ctrl_o = '{code: code_q, preload: pre_q, rsvd: '0,
                      en: en_q, clr: clr_q, ovf: ovf_q};
    assign cnt_o  = cnt_q;

    // R4: a start write seeds the preload byte
    a_r4_start_load: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wf.en && !en_q) |=> (cnt_q == $past(pre_val)));

    // R7: no run and no write means the count holds
    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !wr_i) |=> $stable(cnt_q));

    generate
        if (IS_CYCLE) begin : g_a_cyc
            // R2: master counter steps by one while running
            a_r2_cycle_step: assert property (@(posedge clk) disable iff (rst)
                (run_i && !wr_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
        end else if (STOP_ON_OVF) begin : g_a_stop
            // R9: an overflowed event counter stays put
            a_r9_stop_hold: assert property (@(posedge clk) disable iff (rst)
                (ovf_q && !wr_i) |=> $stable(cnt_q));
        end
    endgenerate
endmodule

// File: rtl/pcu_regdec.sv
module pcu_regdec
    import pcu_pkg::*;
#(
    parameter int N_CTR = 4,
    parameter int AW    = 8
) (
    input  logic [AW-1:0]               addr_i,
    input  logic                        we_i,
    input  logic [N_CTR-1:0][DATA_W-1:0] ctrl_rd_i,
    input  logic [N_CTR-1:0][DATA_W-1:0] cnt_rd_i,
    output logic [N_CTR-1:0]            wr_ctrl_o,
    output logic [DATA_W-1:0]           rdata_o
);
    generate
        for (genvar n = 0; n < N_CTR; n++) begin : g_wdec
            assign wr_ctrl_o[n] = we_i && (addr_i == AW'(ctrl_addr(n)));
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_CTR; i++) begin
            if (addr_i == AW'(ctrl_addr(i)))
                rdata_o = ctrl_rd_i[i];
            if (addr_i == AW'(cnt_addr(i)))
                rdata_o = cnt_rd_i[i];
        end
    end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter int N_CTR       = 4,
    parameter int CNT_W       = 32,
    parameter int EV_W        = 64,
    parameter int AW          = 8,
    parameter bit STOP_ON_OVF = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              we_i,
    output logic [31:0]       rdata_o,
    input  logic [EV_W-1:0]   ev_i,
    output logic              irq_o
);
    ctrl_t                         ctrl_a [N_CTR];
    logic [CNT_W-1:0]              cnt_a  [N_CTR];
    logic [N_CTR-1:0]              hit;
    logic [N_CTR-1:0]              wr_ctrl;
    logic [N_CTR-1:0][DATA_W-1:0]  ctrl_rd;
    logic [N_CTR-1:0][DATA_W-1:0]  cnt_rd;
    logic                          run_all;

    assign run_all = ctrl_a[0].en & ~ctrl_a[0].ovf;

    generate
        for (genvar n = 0; n < N_CTR; n++) begin : g_ctr
            if (n == 0) begin : g_master
                assign hit[n] = 1'b0;
            end else begin : g_slave
                pcu_evsel #(.EV_W(EV_W)) u_sel (
                    .strobe_i (ev_i),
                    .code_i   (ctrl_a[n].code),
                    .hit_o    (hit[n])
                );
            end

            pcu_counter #(
                .CNT_W       (CNT_W),
                .IS_CYCLE    (n == 0),
                .STOP_ON_OVF (STOP_ON_OVF)
            ) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .wr_i    (wr_ctrl[n]),
                .wdata_i (wdata_i),
                .run_i   (run_all),
                .hit_i   (hit[n]),
                .ctrl_o  (ctrl_a[n]),
                .cnt_o   (cnt_a[n])
            );

            assign ctrl_rd[n] = ctrl_a[n];
            assign cnt_rd[n]  = DATA_W'(cnt_a[n]);
        end
    endgenerate

    pcu_regdec #(.N_CTR(N_CTR), .AW(AW)) u_dec (
        .addr_i    (addr_i),
        .we_i      (we_i),
        .ctrl_rd_i (ctrl_rd),
        .cnt_rd_i  (cnt_rd),
        .wr_ctrl_o (wr_ctrl),
        .rdata_o   (rdata_o)
    );

    assign irq_o = ctrl_a[0].ovf;

    // R7: the interrupt rises only after the master count was all ones
    a_r7_irq_on_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(cnt_a[0]) == {CNT_W{1'b1}}));

    // R8: only the 0-then-1 clear on counter 0 drops the interrupt
    a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !(wr_ctrl[0] && wdata_i[1] && !ctrl_a[0].clr)) |=> irq_o);
endmodule

// File: tb/sim_pcu_top.sv
module sim_pcu_top;
    localparam int CW = 24;
    localparam int EW = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic [EW-1:0] ev = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pcu_top #(.N_CTR(4), .CNT_W(CW), .EV_W(EW), .AW(8), .STOP_ON_OVF(1'b1)) u0 (
        .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata), .we_i(we),
        .rdata_o(rdata), .ev_i(ev), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin
            expect_reg("R1 ctrl", 8'(4 * i), 32'h0);
            expect_reg("R1 count", 8'(32 + 4 * i), 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_cycle_count;
        wr(8'h00, 32'hFF00_0004);
        repeat (10) @(negedge clk);
        wr(8'h00, 32'hFF00_0000);
        expect_reg("R2 cycle count", 8'h20, 32'd12);
        expect_reg("R11 ctrl0 readback", 8'h00, 32'hFF00_0000);
    endtask

    task automatic t_cycle_clear;
        wr(8'h00, 32'h0);
        expect_reg("R6 zero write keeps count", 8'h20, 32'd12);
        wr(8'h00, 32'h2);
        expect_reg("R6 rising clear", 8'h20, 32'd0);
        expect_reg("R6 ctrl0 clr bit", 8'h00, 32'h2);
    endtask

    task automatic t_event_count;
        wr(8'h04, 32'h2000_0004);
        wr(8'h08, 32'h2100_0004);
        wr(8'h0C, 32'h7000_0004);
        @(negedge clk); ev = '1;
        repeat (5) @(negedge clk);
        ev = '0;
        wr(8'h00, 32'h0000_0004);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            ev = '0;
            ev[8'h20] = 1'b1;
            ev[8'h21] = (i % 2 == 1);
        end
        repeat (3) begin
            @(negedge clk); ev = '1;
        end
        @(negedge clk); ev = '0;
        wr(8'h00, 32'h0);
        expect_reg("R3 ctr1 read cmd", 8'h24, 32'd10);
        expect_reg("R3 ctr2 write cmd", 8'h28, 32'd6);
        expect_reg("R3 ctr3 out of range", 8'h2C, 32'd0);
        expect_reg("R5 R11 ctrl1 readback", 8'h04, 32'h2000_0006);
    endtask

    task automatic t_preload;
        wr(8'h04, 32'h0);
        expect_reg("R5 clear ctr1", 8'h24, 32'd0);
        wr(8'h04, 32'h20AB_0004);
        expect_reg("R4 preload wins over clear", 8'h24, 32'h00AB_0000);
        wr(8'h04, 32'h20AB_0004);
        expect_reg("R5 clear while enabled", 8'h24, 32'd0);
        expect_reg("R11 ctrl1 preload field", 8'h04, 32'h20AB_0006);
    endtask

    task automatic t_dual_overflow;
        wr(8'h04, 32'h0);
        wr(8'h04, 32'h37FF_0006);
        wr(8'h08, 32'h0);
        wr(8'h08, 32'h2010_0006);
        @(negedge clk);
        ev = '0; ev[8'h37] = 1'b1; ev[8'h20] = 1'b1;
        wr(8'h00, 32'h00FF_0004);
        for (int k = 0; k < 70000 && !irq; k++) @(negedge clk);
        ev = '0;
        check("R7 irq raised", {31'b0, irq}, 32'h1);
        expect_reg("R7 ctr0 wrapped", 8'h20, 32'd0);
        expect_reg("R9 ctr1 wrapped same edge", 8'h24, 32'd0);
        expect_reg("R7 ctr2 frozen", 8'h28, 32'h0011_0000);
        expect_reg("R7 ctrl0 ovf", 8'h00, 32'h00FF_0005);
        expect_reg("R9 ctrl1 ovf", 8'h04, 32'h37FF_0007);
        ev = '1;
        repeat (20) @(negedge clk);
        ev = '0;
        expect_reg("R7 ctr0 stays", 8'h20, 32'd0);
        expect_reg("R7 ctr2 stays", 8'h28, 32'h0011_0000);
        check("R8 irq held", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_irq_clear;
        wr(8'h24, 32'h0000_1234);
        expect_reg("R10 count write ignored", 8'h24, 32'd0);
        wr(8'h20, 32'h0000_0005);
        expect_reg("R10 count0 write ignored", 8'h20, 32'd0);
        wr(8'h04, 32'h37FF_0006);
        expect_reg("R10 ovf bit write ignored", 8'h04, 32'h37FF_0007);
        wr(8'h00, 32'h00FF_0000);
        check("R8 irq after zero write", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h0000_0002);
        check("R8 irq dropped", {31'b0, irq}, 32'h0);
        expect_reg("R6 ovf0 cleared", 8'h00, 32'h0000_0002);
        wr(8'h04, 32'h0);
        expect_reg("R5 ovf1 cleared", 8'h04, 32'h0000_0002);
    endtask

    task automatic t_event_overflow;
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h0);
        wr(8'h0C, 32'h31FF_0006);
        @(negedge clk);
        ev = '0; ev[8'h31] = 1'b1;
        wr(8'h00, 32'h0000_0004);
        repeat (65546) @(negedge clk);
        check("R9 no irq on event wrap", {31'b0, irq}, 32'h0);
        expect_reg("R9 ctrl3 ovf", 8'h0C, 32'h31FF_0007);
        expect_reg("R9 ctr3 held at zero", 8'h2C, 32'd0);
        wr(8'h0C, 32'h31FF_0004);
        expect_reg("R9 ctr3 resumes", 8'h2C, 32'd1);
        expect_reg("R5 ctrl3 after clear", 8'h0C, 32'h31FF_0006);
        ev = '0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 195000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 195000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_cycle_count;
        t_cycle_clear;
        t_event_count;
        t_preload;
        t_dual_overflow;
        t_irq_clear;
        t_event_overflow;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule